// File: doc/BRIEF.md
# Board Control Register File with Character Display

This block is the small control window of a development board as seen from a processor bus. A bus master issues single-word reads and writes; the block decodes the offset from the low 20 address bits and holds the state of the board's visible controls: an eight-LED bar, an eight-cell ASCII character display, a general-purpose output byte, and the registers that bit-bang an external I2C target's clock and data lines. A write of a fixed key value to one register produces a one-cycle system reset request.

The display can be loaded one character at a time through eight position registers spaced 8 bytes apart, or all at once: a single write to the hex-word register turns a 32-bit value into eight uppercase hexadecimal characters, most significant nibble in the leftmost cell. All cells and the LED byte are driven out in parallel so that board logic can show them directly. Reads return one cycle after the request; a read of an offset that holds nothing returns zero and raises an error flag with the response.

Top module: `board_ctl_regs`

## Requirements
- R1: A read request (req_valid=1, req_write=0) sampled at a clock edge gives rd_valid=1 with rd_data for exactly the following cycle; with no read request rd_valid stays 0. Only address bits [19:0] select the register; higher address bits are ignored.
- R2: The LED register at offset 0x010 keeps the low 8 bits of a write; led_o[7] is the leftmost LED and led_o[0] the rightmost; a read returns the byte zero-extended. led_o changes only after a write to this offset.
- R3: A write to the hex-word register at offset 0x400 sets every display cell to the uppercase ASCII hex digit ('0'-'9' = 0x30-0x39, 'A'-'F' = 0x41-0x46) of one nibble: cell 0 (leftmost) takes bits [31:28], cell k takes bits [31-4k:28-4k]. This register reads as zero without error.
- R4: The character position registers are at offsets 0x418 + 8*k for k = 0..7; a write stores the low data byte in cell k only, and a read returns cell k zero-extended. Cell k appears on disp_chars_o[8k+7:8k]. Cells change only on a hex-word or position write.
- R5: After reset every display cell holds 0x20 (space) and the LED, general-purpose output, I2C output enable, I2C clock/data, select and stored input registers are all zero.
- R6: The switch register at offset 0x000 always reads zero, without error.
- R7: A write of exactly 0x00000042 to offset 0x500 raises soft_rst_req_o for the single cycle after the write; any other data value raises nothing. Offset 0x500 reads as zero.
- R8: The general-purpose output register (offset 0xA00) keeps 8 bits, the I2C output-enable register (offset 0xB00) keeps bits [1:0] and the I2C select register (offset 0xB18) keeps bit 0; higher data bits are dropped, and reads return the kept bits zero-extended.
- R9: In the I2C output register at offset 0xB10, data bit 1 drives i2c_scl_o and bit 0 drives i2c_sda_o; a read returns those two bits in the same positions. The lines change only after a write to this offset.
- R10: The I2C input register at offset 0xB08 stores the low 8 bits of a write; a read returns the stored byte with bit 0 replaced by the level of i2c_sda_i as sampled through a two-stage synchronizer.
- R11: A read of any offset not listed above (including misaligned offsets between position registers and 0x458 past the last one) returns rd_data = 0 with rd_err = 1 for that response only; a write to such an offset changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address; bits [19:0] decoded |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid (one cycle after request) |
| rd_data | output | 32 | Read response data |
| rd_err | output | 1 | Read hit an undecoded offset |
| led_o | output | 8 | LED bar, bit 7 leftmost |
| disp_chars_o | output | 64 | Eight ASCII cells, cell k at bits [8k+7:8k], cell 0 leftmost |
| soft_rst_req_o | output | 1 | One-cycle system reset request |
| gpo_o | output | 8 | General-purpose output byte |
| i2c_oe_o | output | 2 | I2C output-enable bits |
| i2c_scl_o | output | 1 | I2C clock line drive |
| i2c_sda_o | output | 1 | I2C data line drive |
| i2c_sel_o | output | 1 | I2C target select |
| i2c_sda_i | input | 1 | Live I2C data level from the target |

## Verification
On every cycle the assertions check that a read response follows exactly one cycle after each read request, that an error response carries zero data, that the reset request only follows a keyed write, that the LED byte, the display cells and the I2C lines hold still unless their own register was written, and that a hex-word write leaves only hex digits in every cell. What those properties cannot show is the content: the exact characters and their left-to-right order after a hex-word write, the landing cell of each position write, the bit placement of the I2C lines and the replaced input bit, and which offsets count as undecoded, so the bench's scenarios compare those values against tables computed from the requirements.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

  localparam int unsigned OFF_W      = 20;
  localparam int unsigned STRIDE_SH  = 3;   // position registers 8 bytes apart

  typedef logic [OFF_W-1:0] off_t;

  localparam off_t OFF_SWITCH  = 20'h00000;
  localparam off_t OFF_LED     = 20'h00010;
  localparam off_t OFF_HEXWORD = 20'h00400;
  localparam off_t OFF_CHAR0   = 20'h00418;
  localparam off_t OFF_SOFTRST = 20'h00500;
  localparam off_t OFF_GPO     = 20'h00A00;
  localparam off_t OFF_I2C_OE  = 20'h00B00;
  localparam off_t OFF_I2C_IN  = 20'h00B08;
  localparam off_t OFF_I2C_OUT = 20'h00B10;
  localparam off_t OFF_I2C_SEL = 20'h00B18;

  localparam logic [31:0] SOFTRST_KEY = 32'h0000_0042;
  localparam logic [7:0]  ASCII_SPACE = 8'h20;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_SWITCH,
    SEL_LED,
    SEL_HEXWORD,
    SEL_CHAR,
    SEL_SOFTRST,
    SEL_GPO,
    SEL_I2C_OE,
    SEL_I2C_IN,
    SEL_I2C_OUT,
    SEL_I2C_SEL
  } sel_e;

  // One nibble to its uppercase ASCII hex digit.
  function automatic logic [7:0] nib2ascii(input logic [3:0] n);
    if (n < 4'd10) return 8'(n) + 8'h30;
    else           return 8'(n) + 8'h37;
  endfunction

endpackage

// File: rtl/board_ctl_decode.sv
module board_ctl_decode
  import board_ctl_pkg::*;
#(
  parameter int unsigned CELLS = 8,
  localparam int unsigned IDX_W = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  off_t             off,
  output sel_e             sel,
  output logic [IDX_W-1:0] idx
);

  off_t delta;

  always_comb begin
    delta = off - OFF_CHAR0;
    sel   = SEL_NONE;
    idx   = '0;
    unique case (off)
      OFF_SWITCH:  sel = SEL_SWITCH;
      OFF_LED:     sel = SEL_LED;
      OFF_HEXWORD: sel = SEL_HEXWORD;
      OFF_SOFTRST: sel = SEL_SOFTRST;
      OFF_GPO:     sel = SEL_GPO;
      OFF_I2C_OE:  sel = SEL_I2C_OE;
      OFF_I2C_IN:  sel = SEL_I2C_IN;
      OFF_I2C_OUT: sel = SEL_I2C_OUT;
      OFF_I2C_SEL: sel = SEL_I2C_SEL;
      default: begin
        if (off >= OFF_CHAR0 &&
            delta[STRIDE_SH-1:0] == '0 &&
            delta[OFF_W-1:STRIDE_SH] < (OFF_W-STRIDE_SH)'(CELLS)) begin
          sel = SEL_CHAR;
          idx = delta[STRIDE_SH +: IDX_W];
        end
      end
    endcase
  end

endmodule

// File: rtl/board_ctl_display.sv
module board_ctl_display
  import board_ctl_pkg::*;
#(
  parameter int unsigned CELLS  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hex_we,
  input  logic               char_we,
  input  logic [IDX_W-1:0]   idx,
  input  logic [DATA_W-1:0]  wdata,
  output logic [7:0]         rd_char,
  output logic [8*CELLS-1:0] cells_o
);

  logic [7:0] cell_q [CELLS];

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)
        cell_q[k] <= ASCII_SPACE;
      else if (hex_we)
        cell_q[k] <= nib2ascii(wdata[4*(CELLS-1-k) +: 4]);
      else if (char_we && idx == IDX_W'(k))
        cell_q[k] <= wdata[7:0];
    end

    assign cells_o[8*k +: 8] = cell_q[k];

    // R3: after a hex-word write each cell is a hex digit
    p_hex_digit_r3: assert property (@(posedge clk) disable iff (rst)
      hex_we |=> ((cell_q[k] >= 8'h30 && cell_q[k] <= 8'h39) ||
                  (cell_q[k] >= 8'h41 && cell_q[k] <= 8'h46)));
  end

  assign rd_char = cell_q[idx];

  // R4: cells hold unless a display write was accepted
  p_disp_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!hex_we && !char_we) |=> $stable(cells_o));

endmodule

// File: rtl/board_ctl_i2c.sv
module board_ctl_i2c #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       oe_we,
  input  logic       out_we,
  input  logic       in_we,
  input  logic       sel_we,
  input  logic [7:0] wdata,
  input  logic       sda_i,
  output logic [1:0] oe_o,
  output logic       scl_o,
  output logic       sda_o,
  output logic       sel_o,
  output logic [7:0] in_word
);

  logic [7:0] in_q;
  logic       sda_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_o  <= '0;
      scl_o <= 1'b0;
      sda_o <= 1'b0;
      sel_o <= 1'b0;
      in_q  <= '0;
    end else begin
      if (oe_we)  oe_o  <= wdata[1:0];
      if (out_we) begin
        scl_o <= wdata[1];
        sda_o <= wdata[0];
      end
      if (sel_we) sel_o <= wdata[0];
      if (in_we)  in_q  <= wdata;
    end
  end

  if (SYNC_STAGES == 0) begin : g_nosync
    assign sda_sync = sda_i;
  end else begin : g_sync
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[SYNC_STAGES-2:0], sda_i};
    end
    assign sda_sync = chain_q[SYNC_STAGES-1];
  end

  assign in_word = {in_q[7:1], sda_sync};

  // R9: the I2C lines move only after a write to the output register
  p_i2c_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !out_we |=> $stable({scl_o, sda_o}));

endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import board_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned LED_W       = 8,
  parameter int unsigned GPO_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CELLS      = DATA_W / 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_err,
  output logic [LED_W-1:0]   led_o,
  output logic [8*CELLS-1:0] disp_chars_o,
  output logic               soft_rst_req_o,
  output logic [GPO_W-1:0]   gpo_o,
  output logic [1:0]         i2c_oe_o,
  output logic               i2c_scl_o,
  output logic               i2c_sda_o,
  output logic               i2c_sel_o,
  input  logic               i2c_sda_i
);

  localparam int unsigned IDX_W = (CELLS > 1) ? $clog2(CELLS) : 1;

  off_t             off;
  sel_e             sel;
  logic [IDX_W-1:0] idx;
  logic             wr, rd;
  logic [7:0]       rd_char;
  logic [7:0]       i2c_in_word;
  logic [DATA_W-1:0] rdata_n;
  logic             unused_addr;

  assign off         = req_addr[OFF_W-1:0];
  assign unused_addr = ^req_addr[ADDR_W-1:OFF_W];
  assign wr          = req_valid &&  req_write;
  assign rd          = req_valid && !req_write;

  board_ctl_decode #(.CELLS(CELLS)) u_dec (
    .off (off),
    .sel (sel),
    .idx (idx)
  );

  board_ctl_display #(.CELLS(CELLS), .DATA_W(DATA_W)) u_disp (
    .clk     (clk),
    .rst     (rst),
    .hex_we  (wr && sel == SEL_HEXWORD),
    .char_we (wr && sel == SEL_CHAR),
    .idx     (idx),
    .wdata   (req_wdata),
    .rd_char (rd_char),
    .cells_o (disp_chars_o)
  );

  board_ctl_i2c #(.SYNC_STAGES(SYNC_STAGES)) u_i2c (
    .clk     (clk),
    .rst     (rst),
    .oe_we   (wr && sel == SEL_I2C_OE),
    .out_we  (wr && sel == SEL_I2C_OUT),
    .in_we   (wr && sel == SEL_I2C_IN),
    .sel_we  (wr && sel == SEL_I2C_SEL),
    .wdata   (req_wdata[7:0]),
    .sda_i   (i2c_sda_i),
    .oe_o    (i2c_oe_o),
    .scl_o   (i2c_scl_o),
    .sda_o   (i2c_sda_o),
    .sel_o   (i2c_sel_o),
    .in_word (i2c_in_word)
  );

  // Plain registers owned by the top level
  always_ff @(posedge clk) begin
    if (rst) begin
      led_o          <= '0;
      gpo_o          <= '0;
      soft_rst_req_o <= 1'b0;
    end else begin
      if (wr && sel == SEL_LED) led_o <= req_wdata[LED_W-1:0];
      if (wr && sel == SEL_GPO) gpo_o <= req_wdata[GPO_W-1:0];
      soft_rst_req_o <= wr && sel == SEL_SOFTRST &&
                        req_wdata == DATA_W'(SOFTRST_KEY);
    end
  end

  // Read data selection
  always_comb begin
    rdata_n = '0;
    unique case (sel)
      SEL_LED:     rdata_n = DATA_W'(led_o);
      SEL_CHAR:    rdata_n = DATA_W'(rd_char);
      SEL_GPO:     rdata_n = DATA_W'(gpo_o);
      SEL_I2C_OE:  rdata_n = DATA_W'(i2c_oe_o);
      SEL_I2C_IN:  rdata_n = DATA_W'(i2c_in_word);
      SEL_I2C_OUT: rdata_n = DATA_W'({i2c_scl_o, i2c_sda_o});
      SEL_I2C_SEL: rdata_n = DATA_W'(i2c_sel_o);
      default:     rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      rd_err   <= rd && sel == SEL_NONE;
      rd_data  <= rd ? rdata_n : '0;
    end
  end

  // R1: response exactly one cycle after each read request
  p_rsp_after_rd_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);
  p_no_rsp_r1: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rd_valid);

  // R11: an error response carries zero data
  p_err_zero_r11: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> (rd_valid && rd_data == '0));

  // R7: reset request only after a keyed write to the soft-reset offset
  p_srst_key_r7: assert property (@(posedge clk) disable iff (rst)
    soft_rst_req_o |-> $past(req_valid && req_write &&
                             req_addr[OFF_W-1:0] == OFF_SOFTRST &&
                             req_wdata == DATA_W'(SOFTRST_KEY)));

  // R2: LED byte holds without a write to its offset
  p_led_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write && req_addr[OFF_W-1:0] == OFF_LED) |=> $stable(led_o));

endmodule

// File: tb/tb_board_ctl_regs.sv
module tb_board_ctl_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr  = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid, rd_err;
  logic [31:0] rd_data;
  logic [7:0]  led_o, gpo_o;
  logic [63:0] disp_chars_o;
  logic        soft_rst_req_o;
  logic [1:0]  i2c_oe_o;
  logic        i2c_scl_o, i2c_sda_o, i2c_sel_o;
  logic        i2c_sda_i = 1'b0;

  int checks = 0;
  int fails  = 0;

  logic [31:0] q_data [$];
  logic        q_err  [$];
  string       q_tag  [$];

  always #10 clk = ~clk;   // 50 MHz

  board_ctl_regs dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
    .led_o(led_o), .disp_chars_o(disp_chars_o),
    .soft_rst_req_o(soft_rst_req_o), .gpo_o(gpo_o),
    .i2c_oe_o(i2c_oe_o), .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o),
    .i2c_sel_o(i2c_sel_o), .i2c_sda_i(i2c_sda_i)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected display vector: cell k (bits 8k+7:8k) shows nibble k from the left.
  function automatic logic [63:0] hex_text(input logic [31:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) begin
      logic [3:0] n;
      n = v[31-4*k -: 4];
      r[8*k +: 8] = (n < 10) ? (8'd48 + 8'(n)) : (8'd65 + 8'(n) - 8'd10);
    end
    return r;
  endfunction

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // Driver: pushes the expected response, then issues the read.
  task automatic bus_rd(input logic [31:0] a, input logic [31:0] exp,
                        input logic exp_err, input string tag);
    q_data.push_back(exp); q_err.push_back(exp_err); q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: pops and compares each response as it appears.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (q_data.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1 unexpected response actual=%0h expected=none", rd_data);
      end else begin
        logic [31:0] ed; logic ee; string et;
        ed = q_data.pop_front(); ee = q_err.pop_front(); et = q_tag.pop_front();
        chk({et, " data"}, 64'(rd_data), 64'(ed));
        chk({et, " err"},  64'(rd_err),  64'(ee));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R5: reset state
    chk("R5 led", 64'(led_o), 64'h0);
    chk("R5 disp spaces", disp_chars_o, {8{8'h20}});
    chk("R5 gpo", 64'(gpo_o), 64'h0);
    chk("R5 i2c lines", 64'({i2c_oe_o, i2c_scl_o, i2c_sda_o, i2c_sel_o}), 64'h0);
    chk("R7 no reset at start", 64'(soft_rst_req_o), 64'h0);
    chk("R1 idle no response", 64'(rd_valid), 64'h0);
    bus_rd(32'h0000_0430, 32'h20, 1'b0, "R5 cell3 space");

    // R6: switches
    bus_rd(32'h0000_0000, 32'h0, 1'b0, "R6 switch");

    // R2: LED bar
    bus_wr(32'h0000_0010, 32'h1234_56A5);
    chk("R2 led low byte", 64'(led_o), 64'hA5);
    chk("R2 leftmost led bit7", 64'(led_o[7]), 64'h1);
    bus_rd(32'h0000_0010, 32'hA5, 1'b0, "R2 led readback");
    // R1: upper address bits ignored
    bus_rd(32'hFFF0_0010, 32'hA5, 1'b0, "R1 alias high addr");
    bus_wr(32'h1F00_0010, 32'h0000_0081);
    chk("R1 alias write led", 64'(led_o), 64'h81);

    // R3: hex word
    bus_wr(32'h0000_0400, 32'hDEAD_BEEF);
    chk("R3 hex DEADBEEF", disp_chars_o, hex_text(32'hDEAD_BEEF));
    bus_wr(32'h0000_0400, 32'h0123_4567);
    chk("R3 hex 01234567", disp_chars_o, hex_text(32'h0123_4567));
    chk("R3 cell0 is '0'", 64'(disp_chars_o[7:0]), 64'h30);
    bus_wr(32'h0000_0400, 32'h89AB_CDEF);
    chk("R3 hex 89ABCDEF", disp_chars_o, hex_text(32'h89AB_CDEF));
    bus_rd(32'h0000_0400, 32'h0, 1'b0, "R3 hexword reads zero");

    // R4: position registers
    bus_wr(32'h0000_0418, 32'hFFFF_FF48);   // cell0 'H'
    bus_wr(32'h0000_0450, 32'h0000_0069);   // cell7 'i'
    bus_wr(32'h0000_0428, 32'h0000_002D);   // cell2 '-'
    begin
      logic [63:0] e;
      e = hex_text(32'h89AB_CDEF);
      e[7:0] = 8'h48; e[63:56] = 8'h69; e[23:16] = 8'h2D;
      chk("R4 position writes", disp_chars_o, e);
    end
    bus_rd(32'h0000_0450, 32'h69, 1'b0, "R4 cell7 readback");
    bus_rd(32'h0000_0420, 32'h39, 1'b0, "R4 cell1 untouched");

    // R7: soft reset
    bus_wr(32'h0000_0500, 32'h0000_0042);
    chk("R7 pulse high", 64'(soft_rst_req_o), 64'h1);
    @(negedge clk);
    chk("R7 pulse one cycle", 64'(soft_rst_req_o), 64'h0);
    bus_wr(32'h0000_0500, 32'h0000_0043);
    chk("R7 wrong key", 64'(soft_rst_req_o), 64'h0);
    bus_wr(32'h0000_0500, 32'h0100_0042);
    chk("R7 key upper bits", 64'(soft_rst_req_o), 64'h0);
    bus_rd(32'h0000_0500, 32'h0, 1'b0, "R7 reads zero");

    // R8: gpo, oe, select
    bus_wr(32'h0000_0A00, 32'hFFFF_FF3C);
    chk("R8 gpo", 64'(gpo_o), 64'h3C);
    bus_wr(32'h0000_0B00, 32'hFFFF_FFFE);
    chk("R8 oe two bits", 64'(i2c_oe_o), 64'h2);
    bus_wr(32'h0000_0B18, 32'hFFFF_FFFF);
    chk("R8 sel one bit", 64'(i2c_sel_o), 64'h1);
    bus_rd(32'h0000_0A00, 32'h3C, 1'b0, "R8 gpo readback");
    bus_rd(32'h0000_0B00, 32'h2, 1'b0, "R8 oe readback");
    bus_rd(32'h0000_0B18, 32'h1, 1'b0, "R8 sel readback");

    // R9: I2C output lines
    bus_wr(32'h0000_0B10, 32'h0000_0002);
    chk("R9 scl=1 sda=0", 64'({i2c_scl_o, i2c_sda_o}), 64'h2);
    bus_wr(32'h0000_0B10, 32'hFFFF_FFFD);
    chk("R9 scl=0 sda=1", 64'({i2c_scl_o, i2c_sda_o}), 64'h1);
    bus_rd(32'h0000_0B10, 32'h1, 1'b0, "R9 out readback");

    // R10: I2C input with live data bit
    bus_wr(32'h0000_0B08, 32'h0000_00A4);
    i2c_sda_i = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(32'h0000_0B08, 32'hA5, 1'b0, "R10 sda high");
    i2c_sda_i = 1'b0;
    bus_wr(32'h0000_0B08, 32'h0000_00FF);
    repeat (4) @(negedge clk);
    bus_rd(32'h0000_0B08, 32'hFE, 1'b0, "R10 sda low");

    // R11: undecoded offsets
    bus_rd(32'h0000_0404, 32'h0, 1'b1, "R11 gap offset");
    bus_rd(32'h0000_041C, 32'h0, 1'b1, "R11 misaligned position");
    bus_rd(32'h0000_0458, 32'h0, 1'b1, "R11 past last position");
    bus_rd(32'h0000_0010, 32'h81, 1'b0, "R11 err clears next read");
    begin
      logic [63:0] d0;
      d0 = disp_chars_o;
      bus_wr(32'h0000_0020, 32'hFFFF_FFFF);
      bus_wr(32'h0000_041C, 32'hFFFF_FFFF);
      chk("R11 write ignored led", 64'(led_o), 64'h81);
      chk("R11 write ignored gpo", 64'(gpo_o), 64'h3C);
      chk("R11 write ignored disp", disp_chars_o, d0);
    end

    repeat (3) @(negedge clk);
    chk("R1 all responses seen", 64'(q_data.size()), 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule